// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter with a write guard on its control registers. Software cannot change the match value, the enable bits or the status flag directly. It must first write an opening code to the first key register, then a closing code to the second key register. The next single register write is then examined. If it targets a guarded register it takes effect, and in every case the guard closes again straight away. A write that breaks the sequence sends the guard back to its closed state.

Once counting is enabled, the counter rises by one each clock and is compared with the match value. When the two are equal, the block raises a sticky status flag and the counter starts again from zero. If reset generation is also enabled, the match additionally produces a reset request that lasts a fixed number of cycles. While that request is high the counter stays at zero. Registers are reached through a synchronous write port and a combinational read port.

Top module: `wdog_keylock`

## Requirements
- R1: After reset:
  - the match register reads 0xFFFF;
  - control, status and count all read 0;
  - `wdog_rst` is low.
- R2: Register addresses are: 0 first key, 1 second key, 2 match value, 3 control, 4 status, 5 count (read only). Addresses 0, 1 and any other address not listed read 0.
- R3: Writing 0xBABA to address 0 and then 0xEB10 to address 1 on the next write opens the guard. The following write to address 2, 3 or 4 takes effect.
- R4: Any write made while the guard is open closes it again, whatever its address. A second guarded write that follows without a new key sequence has no effect.
- R5: Each of the following leaves the guard closed, so the next guarded write has no effect:
  - a wrong first key;
  - a second key with no first key before it;
  - any other write between the two keys, including a second write of the first key.
- R6: Writes to addresses 2, 3 or 4 while the guard is closed leave all register contents unchanged.
- R7: Control bit 0 enables counting. While it is set, and no reset pulse is active, the count rises by one per cycle from 0. While it is clear, the count is held at 0.
- R8: When the count equals the match value and counting is enabled, the next cycle shows status bit 0 set and the count at 0. With control bit 1 clear, matches therefore recur every match+1 cycles and no reset pulse is produced.
- R9: With control bit 1 set, each match drives `wdog_rst` high for exactly 4 cycles, starting the cycle after the match. The count stays at 0 during the pulse and resumes counting once the pulse ends.
- R10: An accepted write to status ANDs its bit 0 with data bit 0, so writing 0 clears the flag. If a match occurs in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |
| wdog_rst | output | 1 | Reset request pulse |

## Verification
Two things can land on the status flag in the same clock: a match that sets it, and an accepted write of 0 that clears it. The bench arranges this by watching the count. When the count is two below the match value, it issues the two key writes and the status write back to back, so the clear reaches the edge on which the match fires. The flag must read 1 and the count 0 afterwards. The same clear issued away from a match must read 0. Random write sequences that mix correct and wrong keys are checked against a reference model of the guard kept in the bench.

// File: rtl/wdkl_pkg.sv
package wdkl_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 3;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_e;

  localparam logic [AW-1:0] A_KEY1  = AW'(0);
  localparam logic [AW-1:0] A_KEY2  = AW'(1);
  localparam logic [AW-1:0] A_MATCH = AW'(2);
  localparam logic [AW-1:0] A_CTRL  = AW'(3);
  localparam logic [AW-1:0] A_STAT  = AW'(4);
  localparam logic [AW-1:0] A_COUNT = AW'(5);

  localparam logic [DW-1:0] CODE_OPEN  = 16'hBABA;
  localparam logic [DW-1:0] CODE_CLOSE = 16'hEB10;

  // guard state after one write
  function automatic lock_e lock_step(lock_e cur, logic [AW-1:0] a, logic [DW-1:0] d);
    case (cur)
      LK_SHUT: return (a == A_KEY1 && d == CODE_OPEN) ? LK_HALF : LK_SHUT;
      LK_HALF: return (a == A_KEY2 && d == CODE_CLOSE) ? LK_OPEN : LK_SHUT;
      default: return LK_SHUT;
    endcase
  endfunction

  function automatic logic is_guarded(logic [AW-1:0] a);
    return (a == A_MATCH) || (a == A_CTRL) || (a == A_STAT);
  endfunction

  function automatic logic [DW-1:0] count_step(logic [DW-1:0] cnt, logic run,
                                               logic hold, logic hit);
    if (!run || hold || hit) return '0;
    return cnt + DW'(1);
  endfunction
endpackage

// File: rtl/wdkl_unlock.sv
module wdkl_unlock
  import wdkl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output lock_e         lock_st,
  output logic          grant
);
  lock_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     st_q <= LK_SHUT;
    else if (wr_en) st_q <= lock_step(st_q, wr_addr, wr_data);
  end

  assign lock_st = st_q;
  assign grant   = wr_en && (st_q == LK_OPEN) && is_guarded(wr_addr);
endmodule

// File: rtl/wdkl_regs.sv
module wdkl_regs
  import wdkl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          hit,
  output logic [DW-1:0] match_q,
  output logic [1:0]    ctrl_q,
  output logic          status_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= '1;
      ctrl_q  <= '0;
    end else if (grant) begin
      if (wr_addr == A_MATCH) match_q <= wr_data;
      if (wr_addr == A_CTRL)  ctrl_q  <= wr_data[1:0];
    end
  end

  // a match outranks a clearing write
  always_ff @(posedge clk) begin
    if (!rst_n)                            status_q <= 1'b0;
    else if (hit)                          status_q <= 1'b1;
    else if (grant && wr_addr == A_STAT)   status_q <= status_q & wr_data[0];
  end
endmodule

// File: rtl/wdkl_count.sv
module wdkl_count
  import wdkl_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          rst_gen,
  input  logic [DW-1:0] match_q,
  output logic [DW-1:0] cnt_q,
  output logic          hit,
  output logic          pulse_on,
  output logic          rst_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] pulse_q;

  assign pulse_on = (pulse_q != '0);
  assign hit      = run && !pulse_on && (cnt_q == match_q);
  assign rst_o    = pulse_on;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= count_step(cnt_q, run, pulse_on, hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               pulse_q <= '0;
    else if (hit && rst_gen)  pulse_q <= PW'(PULSE_LEN);
    else if (pulse_on)        pulse_q <= pulse_q - PW'(1);
  end
endmodule

// File: rtl/wdog_keylock.sv
module wdog_keylock
  import wdkl_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          wdog_rst
);
  lock_e         lock_st;
  logic          grant;
  logic          hit;
  logic          pulse_on;
  logic [DW-1:0] match_q;
  logic [1:0]    ctrl_q;
  logic          status_q;
  logic [DW-1:0] cnt_q;

  wdkl_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lock_st(lock_st), .grant(grant)
  );

  wdkl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .grant(grant), .wr_addr(wr_addr),
    .wr_data(wr_data), .hit(hit), .match_q(match_q), .ctrl_q(ctrl_q),
    .status_q(status_q)
  );

  wdkl_count #(.PULSE_LEN(PULSE_LEN)) u_count (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[0]), .rst_gen(ctrl_q[1]),
    .match_q(match_q), .cnt_q(cnt_q), .hit(hit), .pulse_on(pulse_on),
    .rst_o(wdog_rst)
  );

  always_comb begin
    case (rd_addr)
      A_MATCH: rd_data = match_q;
      A_CTRL:  rd_data = {{(DW-2){1'b0}}, ctrl_q};
      A_STAT:  rd_data = {{(DW-1){1'b0}}, status_q};
      A_COUNT: rd_data = cnt_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdog_keylock_chk.sv
module wdog_keylock_chk
  import wdkl_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input lock_e         lock_st,
  input logic          grant,
  input logic          hit,
  input logic          pulse_on,
  input logic          wdog_rst,
  input logic [DW-1:0] match_q,
  input logic [1:0]    ctrl_q,
  input logic          status_q,
  input logic [DW-1:0] cnt_q
);
  localparam int unsigned RW = $clog2(PULSE_LEN + 1) + 1;
  logic [RW-1:0] high_run;

  always_ff @(posedge clk) begin
    if (!rst_n)        high_run <= '0;
    else if (wdog_rst) high_run <= high_run + RW'(1);
    else               high_run <= '0;
  end

  assert_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (lock_st == LK_SHUT));

  assert_locked_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_guarded(wr_addr) && lock_st != LK_OPEN) |=> ($stable(match_q) && $stable(ctrl_q)));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && !hit && !pulse_on) |=> (cnt_q == DW'($past(cnt_q) + DW'(1))));

  assert_match_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (status_q && cnt_q == '0));

  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_rst) |-> $past(hit && ctrl_q[1]));

  assert_pulse_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    high_run <= RW'(PULSE_LEN));

  assert_pulse_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdog_rst) |-> (high_run == RW'(PULSE_LEN)));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && grant && wr_addr == A_STAT) |=> status_q);
endmodule

bind wdog_keylock wdog_keylock_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .lock_st(lock_st), .grant(grant), .hit(hit), .pulse_on(pulse_on),
  .wdog_rst(wdog_rst), .match_q(match_q), .ctrl_q(ctrl_q),
  .status_q(status_q), .cnt_q(cnt_q)
);

// File: tb/wdog_keylock_test.sv
module wdog_keylock_test;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam logic [DW-1:0] K1 = 16'hBABA;
  localparam logic [DW-1:0] K2 = 16'hEB10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          wdog_rst;

  int n_chk = 0;
  int n_bad = 0;

  // bench reference of the guard: 0 shut, 1 half, 2 open
  int            m_lock = 0;
  logic [DW-1:0] m_match = 16'hFFFF;
  logic [1:0]    m_ctrl = 2'b00;
  logic          m_stat = 1'b0;

  always #10 clk = ~clk;

  wdog_keylock uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wdog_rst(wdog_rst)
  );

  function automatic int next_lock(int cur, logic [AW-1:0] a, logic [DW-1:0] d);
    if (cur == 0) return (a == 3'd0 && d == K1) ? 1 : 0;
    if (cur == 1) return (a == 3'd1 && d == K2) ? 2 : 0;
    return 0;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    bit open;
    open = (m_lock == 2);
    if (open && a == 3'd2) m_match = d;
    if (open && a == 3'd3) m_ctrl = d[1:0];
    if (open && a == 3'd4) m_stat = m_stat & d[0];
    m_lock = next_lock(m_lock, a, d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic unlock();
    wr(3'd0, K1);
    wr(3'd1, K2);
  endtask

  task automatic check_regs(string tag);
    logic [DW-1:0] v;
    rd(3'd2, v); check({tag, " match"}, v, m_match);
    rd(3'd3, v); check({tag, " ctrl"}, v, {14'b0, m_ctrl});
    rd(3'd4, v); check({tag, " status"}, v, {15'b0, m_stat});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] v;
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 map
    check_regs("R1");
    rd(3'd5, v); check("R1 count", v, '0);
    check("R1 wdog_rst", {15'b0, wdog_rst}, 16'd0);
    rd(3'd0, v); check("R2 key1 reads 0", v, '0);
    rd(3'd1, v); check("R2 key2 reads 0", v, '0);
    rd(3'd7, v); check("R2 unused reads 0", v, '0);

    // R6 locked write ignored
    wr(3'd2, 16'h0005);
    check_regs("R6 locked");

    // R3 unlock then accept, R4 second write ignored
    unlock();
    wr(3'd2, 16'h0123);
    check_regs("R3 accept");
    wr(3'd2, 16'h0456);
    check_regs("R4 relock");
    // R4 any write while open closes it
    unlock();
    wr(3'd5, 16'h0000);
    wr(3'd3, 16'h0002);
    check_regs("R4 non-guarded write closes");

    // R5 aborts
    wr(3'd0, 16'hBABB); wr(3'd1, K2); wr(3'd2, 16'h0777);
    check_regs("R5 wrong key1");
    wr(3'd1, K2); wr(3'd2, 16'h0778);
    check_regs("R5 key2 alone");
    wr(3'd0, K1); wr(3'd6, 16'h0); wr(3'd1, K2); wr(3'd2, 16'h0779);
    check_regs("R5 intervening write");
    wr(3'd0, K1); wr(3'd0, K1); wr(3'd1, K2); wr(3'd2, 16'h077A);
    check_regs("R5 repeated key1");

    // constrained random guard traffic, counting kept off
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int pick;
      a = AW'($urandom_range(0, 6));
      pick = $urandom_range(0, 3);
      d = (pick == 0) ? K1 : (pick == 1) ? K2 : DW'($urandom);
      if (a == 3'd3) d[0] = 1'b0;
      wr(a, d);
      check_regs("R3/R4/R5/R6 random");
    end

    // R7/R8 counting without reset generation, match 5
    unlock(); wr(3'd3, 16'h0000);
    unlock(); wr(3'd2, 16'd5);
    unlock(); wr(3'd3, 16'h0001);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      rd(3'd5, v); check("R7 count step", v, DW'(k));
    end
    rd(3'd4, v); check("R8 status before match", v, 16'd0);
    @(negedge clk);
    rd(3'd4, v); check("R8 status after match", v, 16'd1);
    rd(3'd5, v); check("R8 count restarts", v, 16'd0);
    check("R8 no pulse", {15'b0, wdog_rst}, 16'd0);
    m_stat = 1'b1;
    repeat (6) @(negedge clk);
    rd(3'd5, v); check("R8 period", v, 16'd0);
    check("R8 no pulse later", {15'b0, wdog_rst}, 16'd0);

    // R10 collision: clear arrives on the match edge
    do begin rd(3'd5, v); if (v != 16'd3) @(negedge clk); end while (v != 16'd3);
    unlock(); wr(3'd4, 16'h0000);
    rd(3'd4, v); check("R10 set wins over clear", v, 16'd1);
    rd(3'd5, v); check("R10 count after match", v, 16'd0);
    // R10 clear away from a match
    unlock(); wr(3'd4, 16'h0000);
    rd(3'd4, v); check("R10 clear", v, 16'd0);

    // R7 disable holds count at 0
    unlock(); wr(3'd3, 16'h0000);
    @(negedge clk);
    rd(3'd5, v); check("R7 disabled count", v, 16'd0);

    // R9 reset pulse, match 3
    unlock(); wr(3'd2, 16'd3);
    unlock(); wr(3'd4, 16'h0000);
    unlock(); wr(3'd3, 16'h0003);
    repeat (3) @(negedge clk);
    check("R9 before pulse", {15'b0, wdog_rst}, 16'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 pulse high", {15'b0, wdog_rst}, 16'd1);
      rd(3'd5, v); check("R9 count held", v, 16'd0);
    end
    @(negedge clk);
    check("R9 pulse ended", {15'b0, wdog_rst}, 16'd0);
    rd(3'd5, v); check("R9 count still 0", v, 16'd0);
    @(negedge clk);
    rd(3'd5, v); check("R9 count resumes", v, 16'd1);
    rd(3'd4, v); check("R9 status set", v, 16'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule